// File: doc/BRIEF.md
# Edge-Tracking Oversampled Bit Recovery

This block recovers the data of a serial line that carries no clock. It runs on a local sample clock that is several times faster than the bit rate. The default is five samples per bit. The line first passes through a flop synchronizer. Every level change seen on the synchronized line restarts a sample-phase counter, so the sampling point follows the transmitter's edges. No loop filter is used.

A recovered bit is taken a fixed number of samples after the last transition. It is presented on `bit_out` together with a one-cycle `bit_valid` strobe. During runs of equal bits there are no edges, so the counter wraps once per bit period and keeps producing one bit per period. A guard stops two strobes from being issued closer together than a minimum spacing. This prevents double-sampling when an edge re-phases the counter just after a bit has been taken. Pattern search and framing belong to the logic downstream.

The tracking controller is a three-state machine:
- `ST_SEEK` is the state after reset. No bits are emitted, and the first transition moves it to `ST_LOCK`.
- `ST_LOCK` emits a bit when the phase counter reaches the sample phase and no edge is present in that cycle. An emission moves it to `ST_HOLD`.
- `ST_HOLD` blocks emissions for MIN_GAP-1 cycles after a bit and then returns to `ST_LOCK`. Edges keep re-phasing the counter in every state.

Top module: `edge_track_cdr`

## Requirements
- R1: `rx_line` passes through SYNC_STAGES (default 2) flops before any use. A change driven on the line therefore has no effect on the outputs within the first four clock edges, counting from the edge that first captures it.
- R2: During and after reset, `bit_valid` and `bit_out` are 0. They stay 0 until the line changes level.
- R3: After a transition, the first strobe appears on the 4th clock edge after the edge that first captured the new level (defaults). `bit_out` then carries the new level.
- R4: While the line holds its level, strobes repeat exactly every OSR (5) clock cycles and carry the held level.
- R5: `bit_valid` is never high in two consecutive cycles.
- R6: Each transition restarts the sample phase. A bit is taken SAMPLE_PHASE (2) samples after the synchronized transition. The strobe due to the old phase is emitted only if no transition falls on its sampling cycle.
- R7: Two strobes are never less than MIN_GAP (3) cycles apart. An emission that would break this is dropped, and the next one waits for the following sample phase. With SAMPLE_PHASE=1, an edge arriving two samples after a taken bit produces no strobe until OSR samples later.
- R8: A 16-bit frame is recovered exactly, with no dropped and no duplicated bits, at bit periods of 4.9, 5.0 and 5.1 samples and with ±1 sample edge jitter. The frame is sent MSB first from an idle-low line, with a leading 1.
- R9: `bit_out` changes only in a cycle where `bit_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OSR times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw asynchronous serial line |
| bit_out | output | 1 | Recovered bit value, registered |
| bit_valid | output | 1 | One-cycle strobe marking a new recovered bit |

## Verification
Two events can land in the same sample cycle: the sample phase wants to take a bit, and a fresh transition wants to restart that phase. They collide whenever the incoming edges drift against the local counter. The bench provokes this case with transitions placed one cycle before, and exactly on, the sampling cycle of a free-running run. It judges the result by the exact cycles and values of the strobes that follow. A second instance with an early sample phase makes the re-phase land inside the guard window. It confirms that the strobe is withheld and resumes one full period later.

// File: rtl/etc_pkg.sv
package etc_pkg;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_LOCK = 2'd1,
        ST_HOLD = 2'd2
    } trk_state_t;

endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/etc_edge.sv
module etc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic edge_hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign edge_hit = lvl ^ prev_q;
endmodule

// File: rtl/etc_phase_fsm.sv
module etc_phase_fsm
    import etc_pkg::*;
#(
    parameter int OSR          = 5,
    parameter int SAMPLE_PHASE = 2,
    parameter int MIN_GAP      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    output logic take
);
    localparam int CW        = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int HW        = $clog2(MIN_GAP) + 1;
    localparam logic [CW-1:0] PH_VAL   = CW'(SAMPLE_PHASE);
    localparam logic [CW-1:0] WRAP_VAL = CW'(OSR - 1);
    localparam logic [HW-1:0] HOLD_END = HW'(MIN_GAP - 2);

    trk_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [HW-1:0] hold_q, hold_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hold_q  <= hold_d;
        end
    end

    // phase counter: restarts on every edge, wraps once per bit
    always_comb begin
        if (edge_hit)             cnt_d = CW'(1);
        else if (cnt_q == WRAP_VAL) cnt_d = '0;
        else                      cnt_d = cnt_q + CW'(1);
    end

    // guard window counter
    always_comb begin
        if (state_q == ST_HOLD) hold_d = hold_q + HW'(1);
        else                    hold_d = '0;
    end

    // next state and emission decision
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_SEEK: begin
                if (edge_hit) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (!edge_hit && cnt_q == PH_VAL) begin
                    take    = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hold_q == HOLD_END) state_d = ST_LOCK;
            end
            default: state_d = ST_SEEK;
        endcase
    end
endmodule

// File: rtl/etc_bit_reg.sv
module etc_bit_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic lvl,
    output logic bit_out,
    output logic bit_valid
);
    // output process: value and strobe leave together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= take;
            if (take) bit_out <= lvl;
        end
    end
endmodule

// File: rtl/edge_track_cdr.sv
module edge_track_cdr #(
    parameter int OSR          = 5,
    parameter int SAMPLE_PHASE = 2,
    parameter int MIN_GAP      = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic bit_out,
    output logic bit_valid
);
    logic lvl_s;
    logic edge_s;
    logic take_s;

    etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (lvl_s)
    );

    etc_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_s),
        .edge_hit (edge_s)
    );

    etc_phase_fsm #(
        .OSR          (OSR),
        .SAMPLE_PHASE (SAMPLE_PHASE),
        .MIN_GAP      (MIN_GAP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_s),
        .take     (take_s)
    );

    etc_bit_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take_s),
        .lvl       (lvl_s),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );
endmodule

// File: rtl/edge_track_cdr_chk.sv
module edge_track_cdr_chk #(
    parameter int MIN_GAP = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rx_line,
    input logic bit_out,
    input logic bit_valid
);
    localparam int GW = $clog2(MIN_GAP + 1) + 1;

    logic [GW-1:0] since_q;
    logic          rx_d;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= GW'(MIN_GAP);
            rx_d    <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            rx_d <= rx_line;
            if (rx_line != rx_d) seen_q <= 1'b1;
            if (bit_valid)                 since_q <= GW'(1);
            else if (since_q < GW'(MIN_GAP)) since_q <= since_q + GW'(1);
        end
    end

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (since_q >= GW'(MIN_GAP)));

    a_r9_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> (bit_valid || $stable(bit_out)));

    a_r2_quiet_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !bit_valid);
endmodule

bind edge_track_cdr edge_track_cdr_chk #(.MIN_GAP(MIN_GAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .bit_out   (bit_out),
    .bit_valid (bit_valid)
);

// File: tb/tb_edge_track_cdr.sv
`timescale 1ns/1ps
module tb_edge_track_cdr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b0;
    logic rx_g = 1'b0;
    logic bo, bv, bo_g, bv_g;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_track_cdr dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx), .bit_out(bo), .bit_valid(bv)
    );

    edge_track_cdr #(.SAMPLE_PHASE(1)) dut_guard (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_g), .bit_out(bo_g), .bit_valid(bv_g)
    );

    // stimulus table: frame word, period in 1/100 sample, jitter on/off
    localparam int NV = 8;
    localparam logic [15:0] V_WORD [NV] = '{16'hA5A5, 16'hCCCD, 16'hF0F1, 16'h8E39,
                                            16'hB6DA, 16'hA5A5, 16'hF0F1, 16'h8E39};
    localparam int V_PER [NV] = '{500, 490, 510, 500, 490, 510, 490, 510};
    localparam bit V_JIT [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    bit        cap_en = 1'b0;
    int        cap_n = 0;
    logic [0:63] cap;

    always @(negedge clk) begin
        if (cap_en && bv) begin
            if (cap_n < 64) cap[cap_n] = bo;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bnd(input int i, input int per, input bit jit);
        int b;
        b = (i * per) / 100;
        if (jit && (i % 4 == 2)) b = b + 1;
        if (jit && i > 0 && (i % 4 == 0)) b = b - 1;
        return b;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx = 1'b0; rx_g = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] w, input int per, input bit jit);
        int last_b;
        logic [15:0] got;
        do_reset();
        cap_n = 0;
        cap_en = 1'b1;
        last_b = bnd(15, per, jit);
        for (int c = 0; c <= last_b + 8; c++) begin
            int j;
            j = 0;
            for (int i = 1; i < 16; i++) if (c >= bnd(i, per, jit)) j = i;
            rx = w[15 - j];
            @(negedge clk);
        end
        cap_en = 1'b0;
        got = '0;
        for (int k = 0; k < 16; k++) got[15 - k] = cap[k];
        chk(cap_n == 16, "R8 bit count", cap_n, 16);
        chk(got == w, "R8 recovered word", int'(got), int'(w));
    endtask

    initial begin
        int bad;
        // reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(bv == 1'b0 && bo == 1'b0, "R2 outputs in reset", {bv, bo}, 0);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (bv) bad++;
        end
        chk(bad == 0, "R2 no strobe on idle line", bad, 0);

        // first transition, latency, run cadence, re-phase
        rx = 1'b1;
        bad = 0;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (k <= 4 && bv) bad++;
            if (k == 4) chk(bad == 0, "R1 no early strobe", bad, 0);
            if (k == 5) chk(bv == 1'b1 && bo == 1'b1, "R3 first strobe", {bv, bo}, 3);
            if (k == 6) chk(bv == 1'b0, "R5 one-cycle strobe", bv, 0);
            if (k == 7) chk(bo == 1'b1, "R9 value held", bo, 1);
            if ((k >= 7 && k <= 9) || (k >= 11 && k <= 14) || k == 16 || k == 17) begin
                if (bv) bad++;
            end
            if (k == 10) chk(bv == 1'b1 && bo == 1'b1, "R4 run strobe 2", {bv, bo}, 3);
            if (k == 13) rx = 1'b0;
            if (k == 15) chk(bv == 1'b1 && bo == 1'b1, "R4 run strobe 3", {bv, bo}, 3);
            if (k == 18) chk(bv == 1'b1 && bo == 1'b0, "R6 re-phased strobe", {bv, bo}, 2);
        end
        chk(bad == 0, "R4 no stray strobes in run", bad, 0);

        // guard instance: edge right after an early sample phase
        do_reset();
        rx_g = 1'b1;
        bad = 0;
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (k == 2) rx_g = 1'b0;
            if (k == 4) chk(bv_g == 1'b1 && bo_g == 1'b1, "R7 first guarded strobe", {bv_g, bo_g}, 3);
            if (k >= 5 && k <= 10 && bv_g) bad++;
            if (k == 11) chk(bv_g == 1'b1 && bo_g == 1'b0, "R7 resumed strobe", {bv_g, bo_g}, 2);
        end
        chk(bad == 0, "R7 suppressed double sample", bad, 0);

        // table sweep of rate and jitter
        for (int v = 0; v < NV; v++) run_frame(V_WORD[v], V_PER[v], V_JIT[v]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule